// File: doc/BRIEF.md
# Multidrop-Capable Asynchronous Serial Port

This block is a full-duplex asynchronous serial port driven through a byte-wide register interface. Characters written by software go into a 24-entry transmit queue. The transmitter serializes them onto `txd`. Characters recovered from `rxd` land in a 24-entry receive queue that software drains by reading. The frame format is programmable: it sets the data length, the parity handling and the stop length. A one-byte divisor turns the system clock into a 16x oversampling tick.

Two mode registers share a single address. Each access to that address walks a pointer from the first mode register to the second. A command byte switches each direction on or off, flushes the queues and rewinds the pointer. A command byte that asks for contradictory actions is dropped as a whole. Four channel arrangements are available: normal, automatic echo, local loopback and remote loopback.

For multidrop buses, the parity position carries an address/data flag. A character flagged as an address always enters the receive queue, marked as such, even while the receiver is switched off. A slave can therefore inspect every address and enable its receiver only for the data block meant for it.

Back-pressure is applied at the byte interface. A write to the data address while the transmit queue is full is discarded, so software must see the ready status bit set before writing. A receive character that arrives while the receive queue is full is lost. Internally, each queue exchanges characters with its serializer over valid/ready.

Top module: `uart_md`

## Requirements
- R1: Frame on the line, least significant bit first: a 0 start bit, then 5 to 8 data bits chosen by MR1[1:0] (00=5 up to 11=8), then an optional parity slot chosen by MR1[3:2], then 1 stop bit (MR2[0]=0) or 2 stop bits (MR2[0]=1), all at 1. The MR1[3:2] codes are 00 none, 01 even, 10 odd and 11 multidrop flag. Each bit lasts 16 ticks, and one tick occurs every DIV+1 clocks, where DIV is the byte at address 3.
- R2: The transmit queue holds 24 characters and sends them in order while the transmitter is enabled. A data write (address 2) while the queue is full is discarded. Status bit 2 shows that there is room, and status bit 3 shows that the queue is empty and the line idle.
- R3: The receiver qualifies a start bit by re-sampling it 8 ticks after the falling edge and ignores shorter pulses. When the receiver is enabled, each character goes into a 24-entry queue that a read of address 2 pops. Status bit 0 shows that a character is available.
- R4: Address 0 reaches MR1 and then MR2. After any access, read or write, to MR1, the pointer moves to MR2 and stays there. Command bit 4 returns it to MR1.
- R5: A command write at address 1 uses bit 0 for receiver on, bit 1 for receiver off, bit 2 for transmitter on and bit 3 for transmitter off. A command is rejected entirely, with no field taking effect, when it pairs on with off for one direction or pairs an enable with the flush of the same direction. Status bit 6 and status bit 7 show the receiver and transmitter enables.
- R6: MR2[2:1] selects the channel: 00 normal, 01 echo (`txd` follows `rxd` and the receiver still works), 10 local loop (the transmitter feeds the receiver and `txd` stays 1), 11 remote loop (`txd` follows `rxd` and nothing is received).
- R7: With MR1[3:2]=11, a received character whose flag slot is 1 is queued with its address mark set even when the receiver is off. A character whose flag is 0 is queued only while the receiver is on. Status bit 5 is the address mark of the oldest queued character.
- R8: With MR1[3:2]=11, the flag slot of each transmitted character is the value MR1[4] had when that character was written.
- R9: Status bit 4 rises when characters have been waiting for TOUT_TICKS ticks with no new arrival. A pop, an arrival or a flush clears it.
- R10: After reset, `txd` is 1, both directions are off, the pointer is at MR1, MR1, MR2 and DIV are 0, and the status byte reads 0x0C.
- R11: Command bit 5 flushes the receive queue and command bit 6 flushes the transmit queue.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register address: 0 mode, 1 status/command, 2 data, 3 divisor |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe (pops data, steps the mode pointer) |
| wdata | input | 8 | Write byte |
| rdata | output | 8 | Read byte for the current address |
| rxd | input | 1 | Serial input |
| txd | output | 1 | Serial output |

## Verification
The functions most likely to collide are the command actions carried in one byte. These are an enable together with the flush of the same direction, and a receiver enable and disable together with a pointer rewind. The bench writes such combined bytes and then judges the outcome through the enable bits of the status byte, the queue state and which mode register the next read of address 0 returns. A second overlap occurs when an address-flagged character arrives while the receiver is off. There, the gating and the queue push must act together, and the bench checks this through the availability and address-mark status bits before any enable command is issued.

// File: rtl/uart_md_pkg.sv
package uart_md_pkg;
  localparam logic [1:0] A_MODE = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;
  localparam logic [1:0] A_DIV  = 2'd3;

  typedef enum logic [1:0] {PAR_NONE = 2'b00, PAR_EVEN = 2'b01,
                            PAR_ODD = 2'b10, PAR_MDROP = 2'b11} par_e;
  typedef enum logic [1:0] {CH_NORMAL = 2'b00, CH_ECHO = 2'b01,
                            CH_LLOOP = 2'b10, CH_RLOOP = 2'b11} chan_e;
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP} rx_st_e;

  // keeps only the data bits that the selected length uses
  function automatic logic [7:0] len_mask(input logic [1:0] len);
    return 8'hFF >> (2'd3 - len);
  endfunction
endpackage

// File: rtl/uart_md_fifo.sv
module uart_md_fifo #(
  parameter int W = 9,
  parameter int DEPTH = 24,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign do_push   = in_valid && in_ready;
  assign do_pop    = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= step(wr_ptr);
      if (do_pop)  rd_ptr <= step(rd_ptr);
      count <= count + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= in_data;
  end

  // a push against a full queue must leave the occupancy untouched
  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready && !out_ready && !flush) |=> (count == $past(count)));
  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));
endmodule

// File: rtl/uart_md_tx.sv
module uart_md_tx
  import uart_md_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       en,
  input  logic [1:0] len,
  input  par_e       par,
  input  logic       two_stop,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [8:0] in_data,
  output logic       busy,
  output logic       txd
);
  localparam int FW = 12;

  logic [FW-1:0] shreg, frame;
  logic [3:0]    tcnt, bidx, nbits_q, nbits, ppos;
  logic [7:0]    mask, dm;
  logic          pbit, haspar, load;

  always_comb begin
    mask   = len_mask(len);
    dm     = in_data[7:0] & mask;
    haspar = (par != PAR_NONE);
    unique case (par)
      PAR_EVEN:  pbit = ^dm;
      PAR_ODD:   pbit = ~^dm;
      PAR_MDROP: pbit = in_data[8];
      default:   pbit = 1'b0;
    endcase
    ppos  = 4'd6 + {2'b00, len};
    frame = {3'b111, dm | ~mask, 1'b0};
    if (haspar) frame[ppos] = pbit;
    nbits = 4'd6 + {2'b00, len} + {3'b000, haspar} + (two_stop ? 4'd2 : 4'd1);
  end

  assign in_ready = en && !busy;
  assign load     = in_valid && in_ready;
  assign txd      = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '1;
      tcnt    <= '0;
      bidx    <= '0;
      nbits_q <= '0;
      busy    <= 1'b0;
    end else if (load) begin
      shreg   <= frame;
      nbits_q <= nbits;
      tcnt    <= '0;
      bidx    <= '0;
      busy    <= 1'b1;
    end else if (busy && tick) begin
      if (tcnt == 4'd15) begin
        tcnt  <= '0;
        shreg <= {1'b1, shreg[FW-1:1]};
        if (bidx == nbits_q - 4'd1) busy <= 1'b0;
        else bidx <= bidx + 4'd1;
      end else begin
        tcnt <= tcnt + 4'd1;
      end
    end
  end

  // every frame opens with a low start bit
  p_start_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (txd == 1'b0));
endmodule

// File: rtl/uart_md_rx.sv
module uart_md_rx
  import uart_md_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       rxd,
  input  logic       en,
  input  logic [1:0] len,
  input  par_e       par,
  output logic       out_valid,
  output logic [8:0] out_data
);
  rx_st_e     st;
  logic [3:0] tcnt;
  logic [2:0] bidx, dlast;
  logic [7:0] sh;
  logic       pbit, mark, mid;

  assign dlast = 3'(len) + 3'd4;
  assign mid   = tick && (tcnt == 4'd15);
  assign mark  = (par == PAR_MDROP) && pbit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= RX_IDLE;
      tcnt      <= '0;
      bidx      <= '0;
      sh        <= '0;
      pbit      <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      unique case (st)
        RX_IDLE: if (tick && !rxd) begin
          st   <= RX_START;
          tcnt <= '0;
        end
        RX_START: if (tick) begin
          if (tcnt == 4'd7) begin
            tcnt <= '0;
            bidx <= '0;
            pbit <= 1'b0;
            st   <= rxd ? RX_IDLE : RX_DATA;
          end else tcnt <= tcnt + 4'd1;
        end
        RX_DATA: if (tick) begin
          tcnt <= tcnt + 4'd1;
          if (mid) begin
            sh[bidx] <= rxd;
            if (bidx == dlast) st <= (par != PAR_NONE) ? RX_PAR : RX_STOP;
            else bidx <= bidx + 3'd1;
          end
        end
        RX_PAR: if (tick) begin
          tcnt <= tcnt + 4'd1;
          if (mid) begin
            pbit <= rxd;
            st   <= RX_STOP;
          end
        end
        RX_STOP: if (tick) begin
          tcnt <= tcnt + 4'd1;
          if (mid) begin
            st <= RX_IDLE;
            if (mark || en) begin
              out_valid <= 1'b1;
              out_data  <= {mark, sh & len_mask(len)};
            end
          end
        end
        default: st <= RX_IDLE;
      endcase
    end
  end

  // with the receiver off only address-flagged characters may come out
  p_md_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !en) |-> (par == PAR_MDROP && out_data[8]));
endmodule

// File: rtl/uart_md.sv
module uart_md
  import uart_md_pkg::*;
#(
  parameter int FIFO_DEPTH = 24,
  parameter int TOUT_TICKS = 512,
  localparam int CW = $clog2(FIFO_DEPTH + 1),
  localparam int TW = $clog2(TOUT_TICKS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       rxd,
  output logic       txd
);
  logic [4:0]    mr1;
  logic [2:0]    mr2;
  logic [7:0]    div_reg, div_cnt, status;
  logic          ptr, rx_en, tx_en, tick;
  logic          rxd_q1, rxd_q2, rx_line, tx_line;
  logic          cmd_wr, conflict, cmd_ok, mode_acc, data_wr, data_rd;
  logic          rx_flush, tx_flush;
  par_e          par;
  chan_e         chan;
  logic          rx_valid, rx_in_ready, rx_avail;
  logic [8:0]    rx_data, rx_head;
  logic [CW-1:0] rx_count, tx_count;
  logic          tx_ready, tx_q_valid, tx_q_ready, tx_busy, tx_empty;
  logic [8:0]    tx_q_data;
  logic [TW-1:0] tout_cnt;
  logic          rx_tout;

  assign par  = par_e'(mr1[3:2]);
  assign chan = chan_e'(mr2[2:1]);

  // command decode and conflict screening
  assign cmd_wr   = wr_en && (addr == A_STAT);
  assign conflict = (wdata[0] && wdata[1]) || (wdata[2] && wdata[3]) ||
                    (wdata[0] && wdata[5]) || (wdata[2] && wdata[6]);
  assign cmd_ok   = cmd_wr && !conflict;
  assign rx_flush = cmd_ok && wdata[5];
  assign tx_flush = cmd_ok && wdata[6];
  assign mode_acc = (wr_en || rd_en) && (addr == A_MODE);
  assign data_wr  = wr_en && (addr == A_DATA);
  assign data_rd  = rd_en && (addr == A_DATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1     <= '0;
      mr2     <= '0;
      ptr     <= 1'b0;
      rx_en   <= 1'b0;
      tx_en   <= 1'b0;
      div_reg <= '0;
    end else begin
      if (mode_acc) begin
        if (wr_en && !ptr) mr1 <= wdata[4:0];
        if (wr_en && ptr)  mr2 <= wdata[2:0];
        ptr <= 1'b1;
      end
      if (cmd_ok) begin
        if (wdata[0]) rx_en <= 1'b1;
        if (wdata[1]) rx_en <= 1'b0;
        if (wdata[2]) tx_en <= 1'b1;
        if (wdata[3]) tx_en <= 1'b0;
        if (wdata[4]) ptr   <= 1'b0;
      end
      if (wr_en && addr == A_DIV) div_reg <= wdata;
    end
  end

  // oversampling tick and input synchronizer
  assign tick = (div_cnt == div_reg);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      rxd_q1  <= 1'b1;
      rxd_q2  <= 1'b1;
    end else begin
      div_cnt <= tick ? '0 : div_cnt + 8'd1;
      rxd_q1  <= rxd;
      rxd_q2  <= rxd_q1;
    end
  end

  // channel routing
  always_comb begin
    unique case (chan)
      CH_ECHO:  begin rx_line = rxd_q2;  txd = rxd_q2; end
      CH_LLOOP: begin rx_line = tx_line; txd = 1'b1;   end
      CH_RLOOP: begin rx_line = 1'b1;    txd = rxd_q2; end
      default:  begin rx_line = rxd_q2;  txd = tx_line; end
    endcase
  end

  uart_md_fifo #(.W(9), .DEPTH(FIFO_DEPTH)) u_tx_fifo (
    .clk, .rst_n, .flush(tx_flush),
    .in_valid(data_wr), .in_ready(tx_ready), .in_data({mr1[4], wdata}),
    .out_valid(tx_q_valid), .out_ready(tx_q_ready), .out_data(tx_q_data),
    .count(tx_count)
  );

  uart_md_tx u_tx (
    .clk, .rst_n, .tick, .en(tx_en), .len(mr1[1:0]), .par, .two_stop(mr2[0]),
    .in_valid(tx_q_valid), .in_ready(tx_q_ready), .in_data(tx_q_data),
    .busy(tx_busy), .txd(tx_line)
  );

  uart_md_rx u_rx (
    .clk, .rst_n, .tick, .rxd(rx_line), .en(rx_en), .len(mr1[1:0]), .par,
    .out_valid(rx_valid), .out_data(rx_data)
  );

  uart_md_fifo #(.W(9), .DEPTH(FIFO_DEPTH)) u_rx_fifo (
    .clk, .rst_n, .flush(rx_flush),
    .in_valid(rx_valid), .in_ready(rx_in_ready), .in_data(rx_data),
    .out_valid(rx_avail), .out_ready(data_rd), .out_data(rx_head),
    .count(rx_count)
  );

  // receive idle timeout, counted in ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tout_cnt <= '0;
    else if (rx_valid || data_rd || rx_flush || rx_count == '0) tout_cnt <= '0;
    else if (tick && tout_cnt != TW'(TOUT_TICKS)) tout_cnt <= tout_cnt + 1'b1;
  end
  assign rx_tout = (tout_cnt == TW'(TOUT_TICKS));

  assign tx_empty = (tx_count == '0) && !tx_busy;
  assign status   = {tx_en, rx_en, rx_avail & rx_head[8], rx_tout,
                     tx_empty, tx_ready, !rx_in_ready, rx_avail};

  always_comb begin
    unique case (addr)
      A_MODE:  rdata = ptr ? {5'b0, mr2} : {3'b0, mr1};
      A_STAT:  rdata = status;
      A_DATA:  rdata = rx_avail ? rx_head[7:0] : 8'h00;
      default: rdata = div_reg;
    endcase
  end

  p_cmd_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && conflict) |=> (rx_en == $past(rx_en) && tx_en == $past(tx_en)
                              && ptr == $past(ptr)));
  p_ptr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_acc && !ptr) |=> ptr);
  p_tout_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_tout |-> (rx_count != '0));
endmodule

// File: tb/uart_md_tb_top.sv
module uart_md_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] addr = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rxd = 1'b1;
  logic       txd;

  int checks = 0, errors = 0, mon_frames = 0, echo_err = 0;
  bit mon_on = 1'b0;
  int cfg_dlen = 8, cfg_par = 0, cfg_nstop = 1, bitc = 16;
  logic [8:0] exp_q[$];
  logic [7:0] mg;
  logic       me;
  logic [8:0] mexp;

  uart_md dut_i (.clk, .rst_n, .addr, .wr_en, .rd_en, .wdata, .rdata, .rxd, .txd);

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_mode(input logic [7:0] m1, input logic [7:0] m2);
    wr(2'd1, 8'h10);
    wr(2'd0, m1);
    wr(2'd0, m2);
    cfg_dlen  = 5 + int'(m1[1:0]);
    cfg_par   = int'(m1[3:2]);
    cfg_nstop = m2[0] ? 2 : 1;
  endtask

  function automatic logic extra_bit(input logic [7:0] dm, input bit flag);
    case (cfg_par)
      1: return ^dm;
      2: return ~^dm;
      3: return flag;
      default: return 1'b0;
    endcase
  endfunction

  task automatic exp_push(input logic [7:0] d, input bit flag);
    logic [7:0] dm;
    dm = d & 8'((1 << cfg_dlen) - 1);
    exp_q.push_back({extra_bit(dm, flag), dm});
  endtask

  task automatic drive_bit(input logic b, input bit chk_echo);
    rxd = b;
    repeat (bitc / 2) @(negedge clk);
    if (chk_echo && txd !== b) echo_err++;
    repeat (bitc - bitc / 2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input bit flag, input bit chk_echo);
    logic [7:0] dm;
    dm = d & 8'((1 << cfg_dlen) - 1);
    drive_bit(1'b0, chk_echo);
    for (int i = 0; i < cfg_dlen; i++) drive_bit(dm[i], chk_echo);
    if (cfg_par != 0) drive_bit(extra_bit(dm, flag), chk_echo);
    for (int s = 0; s < cfg_nstop; s++) drive_bit(1'b1, chk_echo);
  endtask

  task automatic drain(input string req);
    int guard = 0;
    while (exp_q.size() != 0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    chk(exp_q.size() == 0, req, exp_q.size(), 0);
    repeat (2 * bitc) @(negedge clk);
  endtask

  // monitor: decodes frames on txd and compares with the scoreboard queue
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on && txd === 1'b0) begin
        mg = '0; me = 1'b0;
        repeat (bitc / 2 - 1) @(negedge clk);
        chk(txd === 1'b0, "R1 start bit", txd, 0);
        for (int i = 0; i < cfg_dlen; i++) begin
          repeat (bitc) @(negedge clk);
          mg[i] = txd;
        end
        if (cfg_par != 0) begin
          repeat (bitc) @(negedge clk);
          me = txd;
        end
        for (int s = 0; s < cfg_nstop; s++) begin
          repeat (bitc) @(negedge clk);
          chk(txd === 1'b1, "R1 stop bit", txd, 1);
        end
        mon_frames++;
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected frame", {me, mg}, 0);
        else begin
          mexp = exp_q.pop_front();
          chk({me, mg} == mexp, "R1 R8 frame content", {me, mg}, mexp);
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int f0, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    chk(txd === 1'b1, "R10 txd idle", txd, 1);
    rd(2'd1, v); chk(v == 8'h0C, "R10 status", v, 8'h0C);
    rd(2'd0, v); chk(v == 8'h00, "R10 mode", v, 0);
    rd(2'd3, v); chk(v == 8'h00, "R10 divisor", v, 0);

    // R4 pointer, R5 rejection of contradictory command
    wr(2'd1, 8'h10); wr(2'd0, 8'h07); wr(2'd0, 8'h01);
    rd(2'd0, v); chk(v == 8'h01, "R4 pointer stays on MR2", v, 8'h01);
    wr(2'd1, 8'h13);
    rd(2'd0, v); chk(v == 8'h01, "R5 rejected rewind", v, 8'h01);
    rd(2'd1, v); chk(v[6] == 1'b0, "R5 rejected rx enable", v[6], 0);
    wr(2'd1, 8'h10);
    rd(2'd0, v); chk(v == 8'h07, "R4 rewind to MR1", v, 8'h07);
    rd(2'd0, v); chk(v == 8'h01, "R4 advance to MR2", v, 8'h01);
    cfg_dlen = 8; cfg_par = 1; cfg_nstop = 2;

    // R1 R2 transmit, 8 bits even parity, two stop bits back to back
    mon_on = 1'b1;
    wr(2'd1, 8'h04);
    exp_push(8'hA5, 0); wr(2'd2, 8'hA5);
    exp_push(8'h3C, 0); wr(2'd2, 8'h3C);
    drain("R1 transmit drained");
    rd(2'd1, v); chk(v[3] == 1'b1, "R2 tx empty after send", v[3], 1);

    // R5 contradictory transmit command, R11 transmit flush
    wr(2'd1, 8'h08);
    wr(2'd2, 8'h11);
    f0 = mon_frames;
    wr(2'd1, 8'h0C);
    repeat (300) @(negedge clk);
    chk(mon_frames == f0, "R5 tx stays off", mon_frames - f0, 0);
    rd(2'd1, v); chk(v[3] == 1'b0 && v[7] == 1'b0, "R5 status after reject", v, 8'h04);
    wr(2'd1, 8'h40);
    rd(2'd1, v); chk(v[3] == 1'b1, "R11 tx flush empties", v[3], 1);

    // R2 full queue, 5 bits, no parity, one stop bit
    set_mode(8'h00, 8'h00);
    for (int i = 0; i < 25; i++) begin
      if (i < 24) exp_push(8'(i * 7 + 3), 0);
      wr(2'd2, 8'(i * 7 + 3));
      if (i == 23) begin
        rd(2'd1, v); chk(v[2] == 1'b0, "R2 full clears ready", v[2], 0);
      end
    end
    f0 = mon_frames;
    wr(2'd1, 8'h04);
    drain("R2 queued characters sent");
    chk(mon_frames - f0 == 24, "R2 overflow write dropped", mon_frames - f0, 24);

    // R3 receive, 8 bits odd parity
    set_mode(8'h0B, 8'h00);
    wr(2'd1, 8'h01);
    send_frame(8'h96, 0, 0);
    rd(2'd1, v); chk(v[0] == 1'b1, "R3 character available", v[0], 1);
    rd(2'd2, v); chk(v == 8'h96, "R3 received byte", v, 8'h96);
    rd(2'd1, v); chk(v[0] == 1'b0, "R3 queue empty after pop", v[0], 0);
    @(negedge clk); rxd = 1'b0; repeat (4) @(negedge clk); rxd = 1'b1;
    repeat (3 * bitc) @(negedge clk);
    rd(2'd1, v); chk(v[0] == 1'b0, "R3 short pulse ignored", v[0], 0);

    // R9 timeout
    send_frame(8'h41, 0, 0);
    repeat (100) @(negedge clk);
    rd(2'd1, v); chk(v[4] == 1'b0, "R9 no early timeout", v[4], 0);
    repeat (700) @(negedge clk);
    rd(2'd1, v); chk(v[4] == 1'b1, "R9 timeout raised", v[4], 1);
    rd(2'd2, v); chk(v == 8'h41, "R9 waiting byte", v, 8'h41);
    rd(2'd1, v); chk(v[4] == 1'b0, "R9 timeout cleared by pop", v[4], 0);

    // R11 receive flush, R5 enable plus flush rejected
    send_frame(8'h22, 0, 0);
    wr(2'd1, 8'h21);
    rd(2'd1, v); chk(v[0] == 1'b1, "R5 enable with flush rejected", v[0], 1);
    wr(2'd1, 8'h20);
    rd(2'd1, v); chk(v[0] == 1'b0, "R11 rx flush empties", v[0], 0);

    // R6 local loop
    mon_on = 1'b0;
    set_mode(8'h03, 8'h04);
    wr(2'd2, 8'h5E);
    bad = 0;
    for (int i = 0; i < 220; i++) begin
      @(negedge clk);
      if (txd !== 1'b1) bad++;
    end
    chk(bad == 0, "R6 local loop holds txd high", bad, 0);
    rd(2'd2, v); chk(v == 8'h5E, "R6 local loop returns byte", v, 8'h5E);

    // R6 echo
    set_mode(8'h03, 8'h02);
    echo_err = 0;
    send_frame(8'hC9, 0, 1);
    chk(echo_err == 0, "R6 echo follows rxd", echo_err, 0);
    rd(2'd2, v); chk(v == 8'hC9, "R6 echo still receives", v, 8'hC9);

    // R6 remote loop
    set_mode(8'h03, 8'h06);
    echo_err = 0;
    send_frame(8'h3A, 0, 1);
    chk(echo_err == 0, "R6 remote loop follows rxd", echo_err, 0);
    rd(2'd1, v); chk(v[0] == 1'b0, "R6 remote loop receives nothing", v[0], 0);

    // R7 multidrop receive with receiver off
    set_mode(8'h0F, 8'h00);
    wr(2'd1, 8'h02);
    send_frame(8'h33, 0, 0);
    rd(2'd1, v); chk(v[0] == 1'b0, "R7 data dropped while off", v[0], 0);
    send_frame(8'h5A, 1, 0);
    rd(2'd1, v); chk(v[0] == 1'b1 && v[5] == 1'b1, "R7 address queued and marked", v[5:0], 6'h21);
    rd(2'd2, v); chk(v == 8'h5A, "R7 address value", v, 8'h5A);
    wr(2'd1, 8'h01);
    send_frame(8'h77, 0, 0);
    rd(2'd1, v); chk(v[0] == 1'b1 && v[5] == 1'b0, "R7 data accepted unmarked", v[5:0], 6'h01);
    rd(2'd2, v); chk(v == 8'h77, "R7 data value", v, 8'h77);

    // R8 multidrop transmit flag
    mon_on = 1'b1;
    set_mode(8'h1F, 8'h00);
    exp_push(8'hC3, 1); wr(2'd2, 8'hC3);
    set_mode(8'h0F, 8'h00);
    exp_push(8'h24, 0); wr(2'd2, 8'h24);
    drain("R8 flagged characters sent");

    // R1 divisor: one tick every two clocks
    wr(2'd3, 8'h01);
    bitc = 32;
    set_mode(8'h03, 8'h00);
    exp_push(8'h6B, 0); wr(2'd2, 8'h6B);
    drain("R1 divided bit time");
    rd(2'd3, v); chk(v == 8'h01, "R1 divisor readback", v, 8'h01);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule